// File: doc/BRIEF.md
# Synchronous Presettable Binary Counter

This block is a synchronous binary up-counter. Its width is a parameter and defaults to four bits. Every change of state happens on the rising edge of a single clock. On each edge it does exactly one of four things: it clears the count to zero, it loads a parallel data word, it increments by one, or it holds. The clear and load controls are active low. Clear outranks load, and load outranks counting.

Counting needs two enables to be high together. The chain enable also gates the carry output. The local enable affects only the count. The carry output is combinational. It is high while the count is all ones and the chain enable is high.

Several counters can be chained into a wider counter. Each stage's carry output drives the chain enable of the next stage, so a higher stage advances only on the clock edge where the stage below it rolls over. Divide-by-N or range counting comes from wiring the carry back to the clear or load input outside the block.

Top module: `sync_preset_counter`

## Requirements
- R1: A rising edge with `clear_n` low sets `count` to zero, whatever the other inputs are.
- R2: A rising edge with `clear_n` high and `load_n` low copies `data_in` into `count`. Bit 0 of `data_in` is the least significant bit of `count`.
- R3: A rising edge with `clear_n` and `load_n` high, and either enable low, leaves `count` unchanged.
- R4: A rising edge with `clear_n`, `load_n`, `en_chain` and `en_local` all high adds one to `count`.
- R5: An increment from the all-ones value (15 at the default width) wraps `count` to zero.
- R6: `carry_out` is 1 exactly when `count` is all ones and `en_chain` is 1. It follows `en_chain` within the same cycle, without waiting for a clock edge.
- R7: `en_local` has no effect on `carry_out`.
- R8: Clear takes priority over load. Load takes priority over counting and is accepted whatever the enables are.
- R9: When two counters share a clock and the lower stage's `carry_out` drives the higher stage's `en_chain`, the pair counts as one binary number of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Active-low synchronous clear |
| load_n | input | 1 | Active-low synchronous parallel load |
| en_chain | input | 1 | Count enable that also gates the carry output |
| en_local | input | 1 | Count enable that affects only the count |
| data_in | input | W | Parallel load value, bit 0 least significant |
| count | output | W | Registered count, bit 0 least significant |
| carry_out | output | 1 | High when the count is all ones and `en_chain` is high |

## Verification
The bench drives clear and load low on the same edge. A design with the priority reversed would load the data word instead of clearing. It also loads with both enables high, where a design that let counting win would increment instead of loading.

It holds at all-ones with each enable dropped in turn:
- A carry also gated by `en_local` would drop when only `en_local` falls.
- A registered carry would lag a mid-cycle change of `en_chain` by one cycle.

The wrap from 15 to 0 catches an increment chain that saturates or misses a carry. A two-stage cascade run for twenty edges catches a higher stage that advances on the wrong edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_COUNT = 2'd1,
    ACT_LOAD  = 2'd2,
    ACT_CLEAR = 2'd3
  } cnt_action_e;
endpackage

// File: rtl/cnt_action_decode.sv
module cnt_action_decode
  import cnt_pkg::*;
(
  input  logic        clear_n,
  input  logic        load_n,
  input  logic        en_chain,
  input  logic        en_local,
  output cnt_action_e action
);
  // Fixed priority: clear, then load, then count, else hold.
  always_comb begin
    if (!clear_n)                   action = ACT_CLEAR;
    else if (!load_n)               action = ACT_LOAD;
    else if (en_chain && en_local)  action = ACT_COUNT;
    else                            action = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_next_value.sv
module cnt_next_value
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  cnt_action_e  action,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] data,
  output logic [W-1:0] nxt
);
  // Toggle-style increment: bit i flips when all lower bits are one.
  logic [W:0]   all_low_ones;
  logic [W-1:0] incr;

  assign all_low_ones[0] = 1'b1;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_tbit
      assign all_low_ones[i+1] = all_low_ones[i] & cur[i];
      assign incr[i]           = cur[i] ^ all_low_ones[i];
    end
  endgenerate

  always_comb begin
    unique case (action)
      ACT_CLEAR: nxt = '0;
      ACT_LOAD:  nxt = data;
      ACT_COUNT: nxt = incr;
      default:   nxt = cur;
    endcase
  end
endmodule

// File: rtl/cnt_carry_detect.sv
module cnt_carry_detect #(
  parameter int W = 4
) (
  input  logic [W-1:0] cur,
  input  logic         en_chain,
  output logic         carry
);
  assign carry = (&cur) & en_chain;
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import cnt_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_chain,
  input  logic         en_local,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] count,
  output logic         carry_out
);
  cnt_action_e  action;
  logic [W-1:0] count_q;
  logic [W-1:0] count_d;

  cnt_action_decode u_decode (
    .clear_n  (clear_n),
    .load_n   (load_n),
    .en_chain (en_chain),
    .en_local (en_local),
    .action   (action)
  );

  cnt_next_value #(.W(W)) u_next (
    .action (action),
    .cur    (count_q),
    .data   (data_in),
    .nxt    (count_d)
  );

  always_ff @(posedge clk) begin
    count_q <= count_d;
  end

  cnt_carry_detect #(.W(W)) u_carry (
    .cur      (count_q),
    .en_chain (en_chain),
    .carry    (carry_out)
  );

  assign count = count_q;
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         clear_n,
  input logic         load_n,
  input logic         en_chain,
  input logic         en_local,
  input logic [W-1:0] data_in,
  input logic [W-1:0] count,
  input logic         carry_out
);
  // The count is unknown until the first clear has been applied.
  logic primed;
  always_ff @(posedge clk) begin
    primed <= (primed === 1'b1) || !clear_n;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (primed !== 1'b1)
    !clear_n |=> count == '0); // R1

  AST_LOAD_DATA: assert property (@(posedge clk) disable iff (primed !== 1'b1)
    (clear_n && !load_n) |=> count == $past(data_in)); // R2

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (primed !== 1'b1)
    (clear_n && load_n && !(en_chain && en_local)) |=> $stable(count)); // R3

  AST_INCREMENT: assert property (@(posedge clk) disable iff (primed !== 1'b1)
    (clear_n && load_n && en_chain && en_local) |=> count == W'($past(count) + 1'b1)); // R4

  AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (primed !== 1'b1)
    carry_out == ((count == {W{1'b1}}) && en_chain)); // R6

  AST_CARRY_NO_LOCAL: assert property (@(posedge clk) disable iff (primed !== 1'b1)
    (!en_chain || count != {W{1'b1}}) |-> !carry_out); // R7
endmodule

bind sync_preset_counter cnt_checker #(.W(W)) u_chk (
  .clk       (clk),
  .clear_n   (clear_n),
  .load_n    (load_n),
  .en_chain  (en_chain),
  .en_local  (en_local),
  .data_in   (data_in),
  .count     (count),
  .carry_out (carry_out)
);

// File: tb/tb_sync_preset_counter.sv
module tb_sync_preset_counter;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         clear_n = 1'b1;
  logic         load_n = 1'b1;
  logic         en_chain = 1'b0;
  logic         en_local = 1'b0;
  logic [W-1:0] data_in = '0;
  logic [W-1:0] count;
  logic         carry_out;
  logic [W-1:0] count_hi;
  logic         carry_hi;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sync_preset_counter #(.W(W)) dut (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_chain(en_chain),
    .en_local(en_local), .data_in(data_in), .count(count), .carry_out(carry_out)
  );

  // Higher stage of a cascade, enabled by the lower stage's carry.
  sync_preset_counter #(.W(W)) dut_hi (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_chain(carry_out),
    .en_local(1'b1), .data_in(data_in), .count(count_hi), .carry_out(carry_hi)
  );

  typedef struct packed {
    logic       clr_n;
    logic       ld_n;
    logic       et;
    logic       ep;
    logic [3:0] d;
    logic [3:0] q;
    logic       co;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b1, 4'd5,  4'd0,  1'b0, 4'd1}, // R1 clear while counting enabled
    '{1'b0, 1'b0, 1'b1, 1'b1, 4'd9,  4'd0,  1'b0, 4'd8}, // R8 clear beats load
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd13, 4'd13, 1'b0, 4'd2}, // R2 load with enables low
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd14, 1'b0, 4'd4}, // R4 increment
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd14, 1'b0, 4'd3}, // R3 hold, chain enable low
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd14, 1'b0, 4'd3}, // R3 hold, local enable low
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd15, 1'b1, 4'd6}, // R6 all ones with chain enable
    '{1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd15, 1'b1, 4'd7}, // R7 local enable low, carry stays
    '{1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd15, 1'b0, 4'd6}, // R6 chain enable low kills carry
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0,  1'b0, 4'd5}, // R5 wrap to zero
    '{1'b1, 1'b0, 1'b1, 1'b1, 4'd3,  4'd3,  1'b0, 4'd8}, // R8 load beats count
    '{1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd4,  1'b0, 4'd4}, // R4 increment
    '{1'b1, 1'b0, 1'b1, 1'b0, 4'd15, 4'd15, 1'b1, 4'd2}  // R2 load all ones
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 5000);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    // Table walk: drive at the falling edge, one rising edge, check at the next falling edge.
    for (int i = 0; i < NV; i++) begin
      clear_n  = VECS[i].clr_n;
      load_n   = VECS[i].ld_n;
      en_chain = VECS[i].et;
      en_local = VECS[i].ep;
      data_in  = VECS[i].d;
      @(negedge clk);
      check($sformatf("R%0d row %0d count", VECS[i].req, i), int'(count), int'(VECS[i].q));
      check($sformatf("R%0d row %0d carry", VECS[i].req, i), int'(carry_out), int'(VECS[i].co));
    end

    // R6: carry follows the chain enable within the cycle (count is 15 here).
    clear_n = 1'b1; load_n = 1'b1; en_local = 1'b0;
    en_chain = 1'b0; #1;
    check("R6 carry falls without edge", int'(carry_out), 0);
    en_chain = 1'b1; #1;
    check("R6 carry rises without edge", int'(carry_out), 1);
    // R7: toggling the local enable leaves the carry alone.
    en_local = 1'b1; #1;
    check("R7 local enable high", int'(carry_out), 1);
    en_local = 1'b0; #1;
    check("R7 local enable low", int'(carry_out), 1);
    check("R3 count held at all ones", int'(count), 15);

    // R1: clear with load low and both enables high, from all ones.
    @(negedge clk);
    clear_n = 1'b0; load_n = 1'b0; en_chain = 1'b1; en_local = 1'b1; data_in = 4'd7;
    @(negedge clk);
    check("R1 clear from all ones", int'(count), 0);
    check("R1 carry after clear", int'(carry_out), 0);

    // R9: two-stage cascade, both cleared above, run 20 increments.
    clear_n = 1'b1; load_n = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      check($sformatf("R9 cascade step %0d", k), int'({count_hi, count}), k);
    end
    check("R9 upper stage carry", int'(carry_hi), 0);

    finish_run();
  end
endmodule